// File: doc/BRIEF.md
# Tagged HDLC Receive Byte FIFO

This block is a synchronous byte queue placed between an HDLC bit-level receiver and a host register interface. The receiver hands over each recovered byte together with a start-of-frame marker, an end-of-frame marker and the result of its frame check. The FIFO turns those markers into a 2-bit tag stored beside the byte. The host therefore learns, for every byte it reads, whether the byte opens a frame, sits inside one, or closes a frame that passed or failed its check.

The read side is show-ahead. The byte and tag at the head are visible before the host pops them, so the host can look at the tag first and decide how to treat the byte. A 2-bit occupancy code compares the fill level against a fixed threshold. This code is registered from the stored count, so it trails every push or pop by one clock. An identical instance with the same encoding can serve as the transmit-side queue.

A write that arrives when no space is left is discarded and sets a sticky overflow flag. A read of an empty queue has no effect.

Top module: `hdlc_tagged_fifo`

## Requirements
- R1: Each accepted write stores the byte with a tag: 2'b01 when the start marker alone is set, 2'b00 when neither marker is set, 2'b10 when the end marker is set and the check-good flag is 1, and 2'b11 when the end marker is set and the check-good flag is 0.
- R2: When the start and end markers are both set on one write, the end-of-frame code (2'b10 or 2'b11) is stored and the start code is not.
- R3: `rd_data` and `rd_tag` show the oldest stored entry whenever the FIFO is not empty. A read strobe removes that entry at the clock edge, and entries leave in the order they were written.
- R4: With a depth of 32 and a threshold of 16, the status code is 2'b00 at count 32, 2'b01 at counts 16 to 31, 2'b11 at counts 1 to 15, and 2'b10 at count 0. The full code overrides the threshold code, and the empty code overrides the below-threshold code.
- R5: `level_status` reflects the count as it stood one clock earlier. It does not change at the same edge where a push or pop changes the count; it changes at the following edge.
- R6: A write and a read in the same cycle on a non-empty FIFO both take effect, and the count stays the same. This holds also when the FIFO is full, and the write is then not treated as an overflow.
- R7: A write without a simultaneous read while the FIFO holds 32 entries is discarded and sets `overflow`. `overflow` stays set until reset, and the count never exceeds 32.
- R8: A read strobe while the FIFO is empty leaves the count at zero and leaves `rd_data` and `rd_tag` unchanged. These outputs keep the data and tag of the last entry popped, or zero if nothing has been popped since reset.
- R9: While reset is held and right after it, the status code is 2'b10, `overflow` is 0, and `rd_data` and `rd_tag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Received byte |
| wr_sof | input | 1 | Byte opens a frame |
| wr_eof | input | 1 | Byte closes a frame |
| wr_crc_ok | input | 1 | Frame check passed (used with wr_eof) |
| rd_en | input | 1 | Read strobe from the host |
| rd_data | output | 8 | Byte at the head of the FIFO |
| rd_tag | output | 2 | Tag of the head byte |
| level_status | output | 2 | Registered occupancy code |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
On every cycle the assertions check four things:
- the status code shows full or empty one clock after the count reached 32 or 0;
- the count never rises above the depth;
- a paired push and pop leaves the count alone, and an empty read leaves the head outputs alone;
- overflow stays set, and a lone write at full raises it.

The single-byte-frame tag rule is also checked as a property. The bench's scenarios are what show the full tag sequence across frames of several lengths and the exact order in which bytes leave. They also show the intermediate threshold codes at counts 1, 15, 16 and 31, and the one-cycle status lag at the crossing from 15 to 16.

// File: rtl/hdlc_rxq_pkg.sv
package hdlc_rxq_pkg;

   typedef enum logic [1:0] {
      TAG_MID     = 2'b00,
      TAG_SOF     = 2'b01,
      TAG_EOF_OK  = 2'b10,
      TAG_EOF_BAD = 2'b11
   } frame_tag_e;

   typedef enum logic [1:0] {
      OCC_FULL  = 2'b00,
      OCC_HIGH  = 2'b01,
      OCC_EMPTY = 2'b10,
      OCC_LOW   = 2'b11
   } occ_code_e;

endpackage

// File: rtl/hdlc_rxq_tagger.sv
module hdlc_rxq_tagger
   import hdlc_rxq_pkg::*;
(
   input  logic       sof,
   input  logic       eof,
   input  logic       crc_ok,
   output logic [1:0] tag
);

   frame_tag_e tag_e;

   // The end-of-frame marker outranks the start marker for one-byte frames.
   always_comb begin
      if (eof)
         tag_e = crc_ok ? TAG_EOF_OK : TAG_EOF_BAD;
      else if (sof)
         tag_e = TAG_SOF;
      else
         tag_e = TAG_MID;
   end

   assign tag = tag_e;

endmodule

// File: rtl/hdlc_rxq_store.sv
module hdlc_rxq_store #(
   parameter  int WORD_W = 10,
   parameter  int DEPTH  = 32,
   localparam int PW     = $clog2(DEPTH),
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_req,
   input  logic              pop_req,
   input  logic [WORD_W-1:0] wr_word,
   output logic [WORD_W-1:0] head_word,
   output logic [CW-1:0]     count,
   output logic              dropped
);

   localparam logic [CW-1:0] CNT_MAX = CW'(DEPTH);
   localparam bit            POW2    = (DEPTH & (DEPTH - 1)) == 0;

   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] last_q;
   logic [PW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic              is_empty, is_full, pop_ok, push_ok;

   assign is_empty = (count == '0);
   assign is_full  = (count == CNT_MAX);
   assign pop_ok   = pop_req & ~is_empty;
   assign push_ok  = push_req & (~is_full | pop_ok);
   assign dropped  = push_req & ~push_ok;

   // Pointer wrap: free-running for power-of-two depths, compare otherwise.
   generate
      if (POW2) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
         last_q <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok) begin
            rd_ptr <= rd_nxt;
            last_q <= mem[rd_ptr];
         end
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         always_ff @(posedge clk) begin
            if (push_ok && wr_ptr == PW'(e))
               mem[e] <= wr_word;
         end
      end
   endgenerate

   // Show-ahead head; an empty queue keeps presenting the last popped word.
   assign head_word = is_empty ? last_q : mem[rd_ptr];

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_MAX);

   // R6
   pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_req && pop_req && !is_empty |=> $stable(count));

   // R8
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop_req && !push_req && is_empty |=> $stable(head_word) && count == '0);

endmodule

// File: rtl/hdlc_rxq_status.sv
module hdlc_rxq_status
   import hdlc_rxq_pkg::*;
#(
   parameter  int DEPTH  = 32,
   parameter  int THRESH = 16,
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   output logic [1:0]    status
);

   occ_code_e code_d, code_q;

   // Priority: full over high, empty over low.
   always_comb begin
      if (count == CW'(DEPTH))
         code_d = OCC_FULL;
      else if (count >= CW'(THRESH))
         code_d = OCC_HIGH;
      else if (count == '0)
         code_d = OCC_EMPTY;
      else
         code_d = OCC_LOW;
   end

   // Registered after the count has settled: one clock behind each transfer.
   always_ff @(posedge clk) begin
      if (!rst_n) code_q <= OCC_EMPTY;
      else        code_q <= code_d;
   end

   assign status = code_q;

endmodule

// File: rtl/hdlc_tagged_fifo.sv
module hdlc_tagged_fifo #(
   parameter  int DATA_W = 8,
   parameter  int DEPTH  = 32,
   parameter  int THRESH = 16,
   localparam int WORD_W = DATA_W + 2,
   localparam int CW     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_sof,
   input  logic              wr_eof,
   input  logic              wr_crc_ok,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        rd_tag,
   output logic [1:0]        level_status,
   output logic              overflow
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("hdlc_tagged_fifo: DATA_W must be at least 1");
      end
      if (DEPTH < 2) begin : g_bad_depth
         $error("hdlc_tagged_fifo: DEPTH must be at least 2");
      end
      if (THRESH < 1 || THRESH >= DEPTH) begin : g_bad_thresh
         $error("hdlc_tagged_fifo: THRESH must lie in 1..DEPTH-1");
      end
   endgenerate

   logic [1:0]        wr_tag;
   logic [WORD_W-1:0] head_word;
   logic [CW-1:0]     count;
   logic              dropped;
   logic              ovf_q;

   hdlc_rxq_tagger u_tagger (
      .sof    (wr_sof),
      .eof    (wr_eof),
      .crc_ok (wr_crc_ok),
      .tag    (wr_tag)
   );

   hdlc_rxq_store #(
      .WORD_W (WORD_W),
      .DEPTH  (DEPTH)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_req  (wr_en),
      .pop_req   (rd_en),
      .wr_word   ({wr_tag, wr_data}),
      .head_word (head_word),
      .count     (count),
      .dropped   (dropped)
   );

   hdlc_rxq_status #(
      .DEPTH  (DEPTH),
      .THRESH (THRESH)
   ) u_status (
      .clk    (clk),
      .rst_n  (rst_n),
      .count  (count),
      .status (level_status)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)       ovf_q <= 1'b0;
      else if (dropped) ovf_q <= 1'b1;
   end

   assign overflow = ovf_q;
   assign rd_data  = head_word[DATA_W-1:0];
   assign rd_tag   = head_word[WORD_W-1:DATA_W];

   // R4 R5
   full_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(count) == CW'(DEPTH) |-> level_status == 2'b00);

   // R4 R5
   empty_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(count) == '0 |-> level_status == 2'b10);

   // R7
   sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   // R7
   drop_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && !rd_en && count == CW'(DEPTH) |=> overflow && count == CW'(DEPTH));

   // R2
   single_frame_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_sof && wr_eof && count == '0
      |=> rd_tag == ($past(wr_crc_ok) ? 2'b10 : 2'b11));

endmodule

// File: tb/tb_hdlc_tagged_fifo.sv
module tb_hdlc_tagged_fifo;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 32;
   localparam int THRESH     = 16;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       wr_en, wr_sof, wr_eof, wr_crc_ok, rd_en;
   logic [7:0] wr_data;
   logic [7:0] rd_data;
   logic [1:0] rd_tag, level_status;
   logic       overflow;

   int  tests = 0;
   int  fails = 0;
   bit  done  = 0;
   byte unsigned next_byte = 8'h00;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hdlc_tagged_fifo dut (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .wr_sof       (wr_sof),
      .wr_eof       (wr_eof),
      .wr_crc_ok    (wr_crc_ok),
      .rd_en        (rd_en),
      .rd_data      (rd_data),
      .rd_tag       (rd_tag),
      .level_status (level_status),
      .overflow     (overflow)
   );

   task automatic check(input bit ok, input string req,
                        input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference model
   logic [9:0] mq[$];
   logic [9:0] m_last;
   logic [1:0] m_status;
   bit         m_ovf;

   function automatic logic [1:0] occ(input int n);
      if (n == DEPTH)       return 2'b00;
      else if (n >= THRESH) return 2'b01;
      else if (n == 0)      return 2'b10;
      else                  return 2'b11;
   endfunction

   always @(posedge clk) begin
      int         n;
      bit         pop, push;
      logic [1:0] t;
      if (!rst_n) begin
         mq.delete();
         m_last   = '0;
         m_status = 2'b10;
         m_ovf    = 0;
      end else begin
         n        = mq.size();
         pop      = rd_en && n != 0;
         push     = wr_en && (n < DEPTH || pop);
         m_status = occ(n);
         t        = wr_eof ? (wr_crc_ok ? 2'b10 : 2'b11) : (wr_sof ? 2'b01 : 2'b00);
         if (pop)  m_last = mq.pop_front();
         if (push) mq.push_back({t, wr_data});
         if (wr_en && !push) m_ovf = 1;
      end
   end

   // Per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      logic [9:0] w;
      if (rst_n === 1'b1 && !done) begin
         w = (mq.size() != 0) ? mq[0] : m_last;
         check(rd_data == w[7:0], "R3 head data", rd_data, w[7:0]);
         check(rd_tag == w[9:8], "R1 head tag", rd_tag, w[9:8]);
         check(level_status == m_status, "R4 R5 status", level_status, m_status);
         check(overflow == m_ovf, "R7 overflow", overflow, m_ovf);
      end
   end

   task automatic push_frame(input int len, input bit good);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         wr_en     = 1'b1;
         wr_data   = next_byte;
         next_byte = next_byte + 8'd1;
         wr_sof    = (i == 0);
         wr_eof    = (i == len - 1);
         wr_crc_ok = good;
      end
      @(negedge clk);
      wr_en  = 1'b0;
      wr_sof = 1'b0;
      wr_eof = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         tests++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] held;
      rst_n = 1'b0; wr_en = 0; wr_sof = 0; wr_eof = 0; wr_crc_ok = 0;
      rd_en = 0; wr_data = '0;
      repeat (3) @(negedge clk);
      check(level_status == 2'b10, "R9 reset status", level_status, 2'b10);
      check(overflow == 1'b0, "R9 reset overflow", overflow, 0);
      check(rd_data == 8'h00, "R9 reset data", rd_data, 0);
      check(rd_tag == 2'b00, "R9 reset tag", rd_tag, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(level_status == 2'b10, "R4 count 0", level_status, 2'b10);

      push_frame(1, 1'b1);
      check(rd_tag == 2'b10, "R2 single-byte frame tag", rd_tag, 2'b10);
      check(level_status == 2'b10, "R5 lag after first push", level_status, 2'b10);
      @(negedge clk);
      check(level_status == 2'b11, "R4 count 1", level_status, 2'b11);

      push_frame(14, 1'b0);
      @(negedge clk);
      check(level_status == 2'b11, "R4 count 15", level_status, 2'b11);

      push_frame(1, 1'b0);
      check(level_status == 2'b11, "R5 lag at 15 to 16", level_status, 2'b11);
      @(negedge clk);
      check(level_status == 2'b01, "R4 count 16", level_status, 2'b01);

      push_frame(15, 1'b1);
      @(negedge clk);
      check(level_status == 2'b01, "R4 count 31", level_status, 2'b01);

      push_frame(1, 1'b1);
      check(level_status == 2'b01, "R5 lag at 31 to 32", level_status, 2'b01);
      @(negedge clk);
      check(level_status == 2'b00, "R4 count 32", level_status, 2'b00);

      // R6: push and pop together while full
      @(negedge clk);
      wr_en = 1; rd_en = 1; wr_sof = 1; wr_eof = 1; wr_crc_ok = 1; wr_data = 8'hA5;
      @(negedge clk);
      wr_en = 0; rd_en = 0; wr_sof = 0; wr_eof = 0;
      @(negedge clk);
      check(level_status == 2'b00, "R6 full kept after paired access", level_status, 2'b00);
      check(overflow == 1'b0, "R6 no overflow on paired access", overflow, 0);

      // R7: lone write while full
      wr_en = 1; wr_data = 8'h5A;
      @(negedge clk);
      wr_en = 0;
      check(overflow == 1'b1, "R7 overflow set", overflow, 1);
      repeat (3) @(negedge clk);
      check(overflow == 1'b1, "R7 overflow sticky", overflow, 1);
      check(level_status == 2'b00, "R7 still full", level_status, 2'b00);

      // Drain through empty
      rd_en = 1;
      repeat (40) @(negedge clk);
      rd_en = 0;
      @(negedge clk);
      check(level_status == 2'b10, "R8 empty after drain", level_status, 2'b10);
      check(rd_data == 8'hA5, "R8 last popped data", rd_data, 8'hA5);
      held = rd_data;
      rd_en = 1;
      repeat (3) @(negedge clk);
      rd_en = 0;
      @(negedge clk);
      check(rd_data == held, "R8 empty read keeps data", rd_data, held);
      check(level_status == 2'b10, "R8 empty read keeps count", level_status, 2'b10);

      // Mixed traffic: frames written while the host reads
      rd_en = 1;
      push_frame(4, 1'b1);
      push_frame(2, 1'b0);
      push_frame(1, 1'b0);
      repeat (10) @(negedge clk);
      rd_en = 0;
      @(negedge clk);
      check(level_status == 2'b10, "R3 mixed traffic drained", level_status, 2'b10);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule